// File: doc/BRIEF.md
# Command-Byte Serial Register Interface

This block is the serial slave front end of a converter-style device. A host clocks bits in on `din` and out on `dout` with a serial clock. Every transaction opens with an eight-bit command byte. The byte says whether the host will write or read, and it names one of eight register addresses. Each address has its own fixed length. The block counts exactly that many bits. It then hands a write to the register file as a single-cycle strobe with address and data. For a read, it samples the register file's read-data input once and shifts that word out. The serial clock is sampled by the fast system clock `clk`. Input bits are taken on rising serial edges, and output bits change on falling serial edges.

There are two further paths. First, a streaming mode lets the host collect the data register every time the converter signals fresh data on `rdy_n`, with no command byte needed. Second, a resynchronisation detector watches `din` in every state. A long unbroken run of ones returns the whole interface to its power-on state and pulses `soft_rst` so that the register file can follow.

States: `S_CMD` (collecting a command byte), `S_WRITE` (collecting write data), `S_LOAD` (sampling read data), `S_READ` (shifting read data out), `S_CWAIT` (streaming mode, waiting for fresh data).

Transitions:
- `S_CMD` moves to `S_WRITE` on a write command to a nonzero address.
- `S_CMD` moves to `S_LOAD` on a read command.
- `S_CMD` moves to `S_CWAIT` on the stream-enable command.
- `S_CMD` stays in `S_CMD` on a write to address 0.
- `S_WRITE` moves to `S_CMD` on the last data bit.
- `S_LOAD` always moves to `S_READ`.
- `S_READ` moves to `S_CMD` on the last bit, or to `S_CWAIT` if streaming is still on.
- `S_CWAIT` moves to `S_LOAD` on a falling edge of `rdy_n`.
- Every state moves to `S_CMD` on a resync.

Top module: `cmd_serial_slave`

## Requirements
- R1: After reset, `dout` is 1, `wr_en`, `rd_stb` and `soft_rst` are 0, and the block waits for a command byte.
- R2: While the first bit of a command would be a 1, the block stays at that first bit position and loads nothing. The first 0 sampled becomes command bit 7, and the next seven bits complete the byte.
- R3: The command byte arrives MSB first. Bit 6 is 1 for read and 0 for write, and bits 5:3 are the address. A completed write raises `wr_en` for exactly one `clk` cycle with `wr_addr` and the MSB-first data right-aligned in `wr_data`.
- R4: Addresses 0, 4 and 5 carry 8 data bits. Addresses 1 and 2 carry 16 data bits. Addresses 3, 6 and 7 carry `DATA_W` data bits (16 or 24).
- R5: A write command to address 0, 3 or 4 produces no `wr_en`. For address 0 the command byte is the whole transaction, and no data bits follow it.
- R6: On a read, `rd_addr` holds the address and `rd_data` is sampled once, with `rd_stb` pulsing for one cycle. The low bits of the word, as many as the register is long, are then shifted out MSB first. The first bit is valid before the first data rising edge, and each later bit changes on a falling edge.
- R7: After each transaction the next sampled bit is treated as the start of a new command byte.
- R8: Command 0x5C enters streaming mode. In that mode, each falling edge of `rdy_n` starts a `DATA_W`-bit readout of address 3 without any command byte.
- R9: While streaming, if the first eight `din` bits of a readout are 0x58 and `rdy_n` is low at the eighth bit, streaming ends when that readout completes. Later falling edges of `rdy_n` then start nothing, and commands are decoded again.
- R10: `RESYNC_ONES` (32) consecutive rising serial edges with `din` high pulse `soft_rst` for one cycle and return the block to its power-on state. This applies in every state, including streaming mode.
- R11: A run of ones shorter than `RESYNC_ONES`, broken by a 0, causes no resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, synchronous to `clk` and idling high |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host, 1 when not reading |
| rdy_n | input | 1 | Active-low fresh-data indication from the converter |
| wr_en | output | 1 | One-cycle register-file write strobe |
| wr_addr | output | 3 | Write address |
| wr_data | output | DATA_W | Write data, right-aligned |
| rd_addr | output | 3 | Address whose contents `rd_data` must present |
| rd_stb | output | 1 | One-cycle pulse after `rd_data` has been sampled |
| rd_data | input | DATA_W | Register-file read data for `rd_addr` |
| soft_rst | output | 1 | One-cycle pulse on a resync by ones |

## Verification
A wrong bit counter or a wrong length lookup puts the block out of frame with the host. This shows within one transaction: the write strobe carries the wrong data, or a read returns shifted bits. It also shows one command later, because the following command byte decodes to the wrong address. A stuck streaming flag appears at the next `rdy_n` falling edge as a read strobe that should not happen. A miscounting ones detector shows as a missing or extra `soft_rst` pulse on the 32nd edge, or as streaming that survives a resync.

// File: rtl/cmd_serial_pkg.sv
package cmd_serial_pkg;

    typedef enum logic [2:0] {
        S_CMD   = 3'd0,
        S_WRITE = 3'd1,
        S_LOAD  = 3'd2,
        S_READ  = 3'd3,
        S_CWAIT = 3'd4
    } state_t;

    localparam logic [2:0] A_STATUS = 3'd0;
    localparam logic [2:0] A_MODE   = 3'd1;
    localparam logic [2:0] A_CONFIG = 3'd2;
    localparam logic [2:0] A_DATA   = 3'd3;
    localparam logic [2:0] A_IDENT  = 3'd4;
    localparam logic [2:0] A_PORT   = 3'd5;
    localparam logic [2:0] A_OFFS   = 3'd6;
    localparam logic [2:0] A_GAIN   = 3'd7;

    localparam logic [7:0] CMD_STREAM_ON  = 8'h5C;
    localparam logic [7:0] CMD_STREAM_OFF = 8'h58;

    // number of data bits carried by a register address
    function automatic int unsigned reg_bits(input logic [2:0] a, input int unsigned dw);
        int unsigned n;
        unique case (a)
            A_STATUS, A_IDENT, A_PORT: n = 8;
            A_MODE, A_CONFIG:          n = 16;
            default:                   n = dw;
        endcase
        return n;
    endfunction

    // addresses whose write data is discarded
    function automatic logic write_dropped(input logic [2:0] a);
        return (a == A_STATUS) || (a == A_DATA) || (a == A_IDENT);
    endfunction

endpackage

// File: rtl/cmd_serial_edges.sv
module cmd_serial_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic rdy_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic rdy_fall
);

    logic sclk_q;
    logic rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            rdy_q  <= 1'b1;
        end else begin
            sclk_q <= sclk;
            rdy_q  <= rdy_n;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;
    assign rdy_fall  = ~rdy_n & rdy_q;

endmodule

// File: rtl/cmd_serial_resync.sv
module cmd_serial_resync #(
    parameter int ONES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic din,
    output logic fire
);

    localparam int CW = (ONES > 2) ? $clog2(ONES) : 1;
    localparam logic [CW-1:0] LAST = CW'(ONES - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (sample) begin
                if (!din) begin
                    run_cnt <= '0;
                end else if (run_cnt == LAST) begin
                    run_cnt <= '0;
                    fire    <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

    // R10: resync is a single-cycle pulse
    assert_fire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R11: a zero sample always clears the run
    assert_zero_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !din) |=> (run_cnt == '0 && !fire));

endmodule

// File: rtl/cmd_serial_slave.sv
module cmd_serial_slave
    import cmd_serial_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int RESYNC_ONES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    input  logic              rdy_n,
    output logic              wr_en,
    output logic [2:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [2:0]        rd_addr,
    output logic              rd_stb,
    input  logic [DATA_W-1:0] rd_data,
    output logic              soft_rst
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    state_t              state;
    state_t              state_nx;
    logic [CNT_W-1:0]    bitcnt;
    logic [CNT_W-1:0]    len;
    logic [DATA_W-1:0]   sh;
    logic [7:0]          cap;
    logic [2:0]          cur_addr;
    logic                cont_q;
    logic                exit_pend;
    logic                shift_pend;

    logic sclk_rise;
    logic sclk_fall;
    logic rdy_fall;

    cmd_serial_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .rdy_n     (rdy_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .rdy_fall  (rdy_fall)
    );

    cmd_serial_resync #(.ONES(RESYNC_ONES)) u_resync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sclk_rise),
        .din    (din),
        .fire   (soft_rst)
    );

    // command decode from the shift register plus the bit now on din
    logic [7:0] cmd_full;
    logic [2:0] cmd_addr;
    logic       cmd_read;
    logic       cmd_go;
    logic       cmd_last;
    logic       data_last;
    logic       exit_hit;

    assign cmd_full  = {sh[6:0], din};
    assign cmd_addr  = cmd_full[5:3];
    assign cmd_read  = cmd_full[6];
    assign cmd_go    = sclk_rise && !(bitcnt == '0 && din);
    assign cmd_last  = cmd_go && (bitcnt == CMD_LAST);
    assign data_last = sclk_rise && (bitcnt == len - ONE);
    assign exit_hit  = cont_q && sclk_rise && (bitcnt == CMD_LAST)
                       && ({cap[6:0], din} == CMD_STREAM_OFF) && !rdy_n;

    assign rd_addr = cur_addr;
    assign dout    = (state == S_READ) ? sh[DATA_W-1] : 1'b1;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_CMD: begin
                if (cmd_last) begin
                    if (cmd_full == CMD_STREAM_ON)
                        state_nx = S_CWAIT;
                    else if (cmd_read)
                        state_nx = S_LOAD;
                    else if (cmd_addr != A_STATUS)
                        state_nx = S_WRITE;
                    else
                        state_nx = S_CMD;
                end
            end
            S_WRITE: if (data_last) state_nx = S_CMD;
            S_LOAD:  state_nx = S_READ;
            S_READ:  if (data_last) state_nx = (cont_q && !exit_pend) ? S_CWAIT : S_CMD;
            S_CWAIT: if (rdy_fall) state_nx = S_LOAD;
            default: state_nx = S_CMD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_CMD;
        else if (soft_rst)
            state <= S_CMD;
        else
            state <= state_nx;
    end

    // datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            len        <= FULL_LEN;
            sh         <= '0;
            cap        <= '0;
            cur_addr   <= A_STATUS;
            cont_q     <= 1'b0;
            exit_pend  <= 1'b0;
            shift_pend <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= A_STATUS;
            wr_data    <= '0;
            rd_stb     <= 1'b0;
        end else if (soft_rst) begin
            bitcnt     <= '0;
            len        <= FULL_LEN;
            sh         <= '0;
            cap        <= '0;
            cur_addr   <= A_STATUS;
            cont_q     <= 1'b0;
            exit_pend  <= 1'b0;
            shift_pend <= 1'b0;
            wr_en      <= 1'b0;
            rd_stb     <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            rd_stb <= 1'b0;
            unique case (state)
                S_CMD: begin
                    if (cmd_last) begin
                        bitcnt   <= '0;
                        sh       <= '0;
                        cur_addr <= cmd_addr;
                        len      <= CNT_W'(reg_bits(cmd_addr, DATA_W));
                        if (cmd_full == CMD_STREAM_ON) cont_q <= 1'b1;
                    end else if (cmd_go) begin
                        sh     <= {sh[DATA_W-2:0], din};
                        bitcnt <= bitcnt + ONE;
                    end
                end
                S_WRITE: begin
                    if (data_last) begin
                        bitcnt <= '0;
                        sh     <= '0;
                        if (!write_dropped(cur_addr)) begin
                            wr_en   <= 1'b1;
                            wr_addr <= cur_addr;
                            wr_data <= {sh[DATA_W-2:0], din};
                        end
                    end else if (sclk_rise) begin
                        sh     <= {sh[DATA_W-2:0], din};
                        bitcnt <= bitcnt + ONE;
                    end
                end
                S_LOAD: begin
                    sh         <= rd_data << (FULL_LEN - len);
                    rd_stb     <= 1'b1;
                    bitcnt     <= '0;
                    cap        <= '0;
                    exit_pend  <= 1'b0;
                    shift_pend <= 1'b0;
                end
                S_READ: begin
                    if (sclk_fall && shift_pend) begin
                        sh         <= {sh[DATA_W-2:0], 1'b0};
                        shift_pend <= 1'b0;
                    end
                    if (sclk_rise) begin
                        cap        <= {cap[6:0], din};
                        shift_pend <= 1'b1;
                        if (exit_hit) exit_pend <= 1'b1;
                        if (data_last) begin
                            bitcnt <= '0;
                            if (exit_pend) cont_q <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + ONE;
                        end
                    end
                end
                S_CWAIT: begin
                    if (rdy_fall) begin
                        cur_addr <= A_DATA;
                        len      <= FULL_LEN;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: write strobe lasts one cycle
    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: no strobe toward a discarded address
    assert_no_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(wr_addr == A_STATUS || wr_addr == A_DATA || wr_addr == A_IDENT));

    // R6: read strobe lasts one cycle and is followed by shifting
    assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (state == S_READ) ##1 !rd_stb);

    // R4: readout never counts past the register length
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |-> (bitcnt < len));

    // R8: streaming mode never collects write data
    assert_stream_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cont_q |-> (state != S_WRITE));

    // R10: resync returns to command wait with streaming off
    assert_resync_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == S_CMD && !cont_q && bitcnt == '0));

endmodule

// File: tb/cmd_serial_slave_tb.sv
module cmd_serial_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;

    typedef struct packed {
        logic [2:0]  a;
        logic [23:0] d;
    } wexp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b1;
    logic          din = 1'b0;
    logic          rdy_n = 1'b1;
    logic          dout;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic [2:0]    rd_addr;
    logic          rd_stb;
    logic [DW-1:0] rd_data;
    logic          soft_rst;
    logic [23:0]   data_val = 24'h000000;

    int n_chk = 0;
    int n_bad = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    int soft_seen = 0;
    bit finished = 1'b0;

    wexp_t      wq[$];
    logic [2:0] rq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] model(input logic [2:0] a);
        return {5'b10100, a, 5'b01101, a, 8'h5A ^ {a, a, 2'b11}};
    endfunction

    function automatic logic [23:0] mask(input int n);
        return 24'hFFFFFF >> (24 - n);
    endfunction

    assign rd_data = (rd_addr == 3'd3) ? data_val : model(rd_addr);

    cmd_serial_slave #(.DATA_W(DW), .RESYNC_ONES(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .dout(dout),
        .rdy_n(rdy_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_stb(rd_stb), .rd_data(rd_data), .soft_rst(soft_rst)
    );

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // monitor: pops expected strobes as the design produces them
    always @(negedge clk) begin
        wexp_t e;
        logic [2:0] ea;
        if (rst_n) begin
            if (wr_en) begin
                wr_seen++;
                if (wq.size() == 0) begin
                    chk(1'b0, "R5 unexpected write strobe", {29'b0, wr_addr}, 32'hFFFF_FFFF);
                end else begin
                    e = wq.pop_front();
                    chk(wr_addr == e.a, "R3 write address", {29'b0, wr_addr}, {29'b0, e.a});
                    chk(wr_data == e.d, "R4 write data", {8'b0, wr_data}, {8'b0, e.d});
                end
            end
            if (rd_stb) begin
                rd_seen++;
                if (rq.size() == 0) begin
                    chk(1'b0, "R9 unexpected read strobe", {29'b0, rd_addr}, 32'hFFFF_FFFF);
                end else begin
                    ea = rq.pop_front();
                    chk(rd_addr == ea, "R6 read address", {29'b0, rd_addr}, {29'b0, ea});
                end
            end
            if (soft_rst) soft_seen++;
        end
    end

    task automatic bitx(input logic b, output logic s);
        @(negedge clk);
        sclk = 1'b0;
        din  = b;
        repeat (3) @(negedge clk);
        s = dout;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(input int n, input logic [23:0] wv, output logic [23:0] rv);
        logic s;
        rv = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bitx(wv[i], s);
            rv = {rv[22:0], s};
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        logic [23:0] dummy;
        xfer(8, {16'b0, c}, dummy);
    endtask

    task automatic ones(input int n);
        logic s;
        for (int i = 0; i < n; i++) bitx(1'b1, s);
    endtask

    task automatic wr(input logic [2:0] a, input int n, input logic [23:0] d, input bit strobe);
        wexp_t t;
        logic [23:0] rv;
        t.a = a;
        t.d = d & mask(n);
        if (strobe) wq.push_back(t);
        send_cmd({2'b00, a, 3'b000});
        xfer(n, d, rv);
    endtask

    task automatic rd(input logic [2:0] a, input int n, input logic [23:0] exp, input string r);
        logic [23:0] rv;
        rq.push_back(a);
        send_cmd({2'b01, a, 3'b000});
        xfer(n, 24'h0, rv);
        chk(rv == (exp & mask(n)), r, {8'b0, rv}, {8'b0, exp & mask(n)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w0;
        int r0;
        int s0;
        logic [23:0] rv;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(dout == 1'b1, "R1 dout idle", {31'b0, dout}, 1);
        chk(wr_en == 1'b0 && rd_stb == 1'b0, "R1 strobes idle", {30'b0, wr_en, rd_stb}, 0);
        chk(soft_rst == 1'b0, "R1 soft_rst idle", {31'b0, soft_rst}, 0);

        // R2 leading ones are held at the first bit position
        ones(5);
        wr(3'd1, 16, 24'h001234, 1'b1);
        ones(3);
        rd(3'd4, 8, model(3'd4), "R2 read after leading ones");

        // R3 R4 widths and data of every writable register
        wr(3'd2, 16, 24'h00BEEF, 1'b1);
        wr(3'd6, 24, 24'hA5C3F0, 1'b1);
        wr(3'd7, 24, 24'h0F1E2D, 1'b1);
        wr(3'd5, 8, 24'h00005A, 1'b1);

        // R6 reads of each length, R7 back to back
        rd(3'd0, 8, model(3'd0), "R6 status read");
        rd(3'd1, 16, model(3'd1), "R6 mode read");
        data_val = 24'hC1A5E7;
        rd(3'd3, 24, 24'hC1A5E7, "R4 data read");
        rd(3'd5, 8, model(3'd5), "R7 back to back read");
        rd(3'd7, 24, model(3'd7), "R4 gain read");

        // R5 dropped writes keep framing
        w0 = wr_seen;
        wr(3'd4, 8, 24'h0000FF, 1'b0);
        wr(3'd3, 24, 24'h123456, 1'b0);
        send_cmd(8'h00);
        chk(wr_seen == w0, "R5 no strobe for dropped writes", wr_seen, w0);
        wr(3'd5, 8, 24'h0000C3, 1'b1);
        repeat (2) @(negedge clk);
        chk(wr_seen == w0 + 1, "R5 framing kept after dropped writes", wr_seen, w0 + 1);

        // R8 streaming mode
        send_cmd(8'h5C);
        data_val = 24'h8137E4;
        rq.push_back(3'd3);
        rdy_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer(24, 24'h0, rv);
        chk(rv == 24'h8137E4, "R8 first streamed word", {8'b0, rv}, 32'h8137E4);
        rdy_n = 1'b1;
        repeat (4) @(negedge clk);
        data_val = 24'h2468AC;
        rq.push_back(3'd3);
        rdy_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer(24, 24'h580000, rv);
        chk(rv == 24'h2468AC, "R8 second streamed word", {8'b0, rv}, 32'h2468AC);
        rdy_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 streaming has ended
        r0 = rd_seen;
        rdy_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(rd_seen == r0, "R9 no stream after exit", rd_seen, r0);
        rdy_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd4, 8, model(3'd4), "R9 command decoded after exit");

        // R10 resync after a write of ones
        s0 = soft_seen;
        wr(3'd1, 16, 24'h00FFFF, 1'b1);
        ones(16);
        repeat (3) @(negedge clk);
        chk(soft_seen == s0 + 1, "R10 resync after 32 ones", soft_seen, s0 + 1);

        // R10 resync in streaming mode
        send_cmd(8'h5C);
        s0 = soft_seen;
        ones(32);
        repeat (3) @(negedge clk);
        chk(soft_seen == s0 + 1, "R10 resync in streaming mode", soft_seen, s0 + 1);
        r0 = rd_seen;
        rdy_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(rd_seen == r0, "R10 streaming cleared by resync", rd_seen, r0);
        rdy_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd2, 16, model(3'd2), "R10 command decoded after resync");

        // R11 short run of ones
        s0 = soft_seen;
        ones(31);
        rd(3'd4, 8, model(3'd4), "R11 read after 31 ones");
        chk(soft_seen == s0, "R11 no resync for 31 ones", soft_seen, s0);

        repeat (4) @(negedge clk);
        chk(wq.size() == 0, "R3 all writes strobed", wq.size(), 0);
        chk(rq.size() == 0, "R6 all reads strobed", rq.size(), 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule